// File: doc/BRIEF.md
# Configurable Serial Test-Pattern Generator

This block is the transmit half of a bit-error-rate tester. Each cycle in which its advance input is high, it emits one bit of a test pattern. There are three modes. The first is a pseudo-random binary sequence from a linear feedback shift register whose length and feedback tap are set at run time. The second repeats the low bits of a 32-bit pattern word. The third is a fixed quasi-random mode that applies zero suppression, so the line never carries a long run of zeros.

Software writes two 8-bit configuration registers through a simple write port. A write only changes the shadow copies. The new setup takes effect at the next load strobe. The load strobe copies the 32-bit pattern word into the shift register, where it serves as the seed or as the repeated pattern, and restarts the sequence.

Top module: `testpat_gen`

## Requirements
- R1: After reset both configuration registers are zero, the shift register holds all ones, and `bit_out` is 1.
- R2: A write to address 0x82 sets the low configuration: bit 6 selects the quasi-random mode, bit 5 selects repeat (1) or PRBS (0), and bits 4..0 hold the length field L. A write to 0x83 sets bits 4..0, the tap field T. Writes to other addresses change nothing. A written value is used only from the next `load` onwards.
- R3: When `load` is high, the pattern word masked to its low n bits (n = L+1) is copied into the shift register. In the following cycle `bit_out` shows the first bit of the new sequence.
- R4: The shift register advances only in cycles where `bit_en` is high and `load` is low. In all other cycles `bit_out` holds its value.
- R5: PRBS mode uses n = L+1 stages. Stage k is state bit k-1, and the output is stage n. On each advance every stage moves up by one, and stage 1 takes the XOR of stage n and stage y, where y = T+1.
- R6: In PRBS mode and in quasi-random mode, a masked seed of zero is replaced by n ones.
- R7: Repeat mode outputs pattern-word bits 0 through L in that order and then starts over. The tap field has no effect, and a zero pattern is kept as zero.
- R8: In quasi-random mode the type, length and tap fields are ignored. The register runs with n = 20 and y = 17, which gives the polynomial x^20 + x^17 + 1.
- R9: In quasi-random mode the output is forced to 1 whenever the next fourteen raw register output bits are all zero. The forced value is never fed back into the register, so no output run of zeros is longer than fourteen. PRBS mode applies no such forcing.
- R10: With L = 14 and T = 13, the sequence repeats with period 32767 and contains 16384 ones per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| pattern_word | input | 32 | Seed or repeat pattern |
| load | input | 1 | Applies the configuration and loads `pattern_word` |
| bit_en | input | 1 | Advance by one bit |
| bit_out | output | 1 | Serial pattern bit |

## Verification
A short 3-stage PRBS loaded with a zero seed shows whether the lock-up fill and the stage/tap mapping are correct. A 15-stage PRBS run for more than a full period separates the correct maximal-length feedback from any other tap or output stage. Repeat patterns of lengths 1, 8 and 32, including an all-zero word, show both the bit order and that the zero-seed rule does not apply in this mode. A quasi-random seed with a single one at the top produces a raw run of 19 zeros. In quasi-random mode this must appear as exactly 6 ones followed by 14 zeros, while the same seed in PRBS mode keeps all 19 zeros. A long random run then confirms the suppression bound and that the forced value never alters the register.

// File: rtl/testpat_pkg.sv
`timescale 1ns/1ps
package testpat_pkg;
    localparam int WORD_W   = 32;
    localparam int FLD_W    = $clog2(WORD_W);
    localparam int QRSS_LEN = 20;
    localparam int QRSS_TAP = 17;
    localparam int ZRUN     = 14;
    localparam logic [7:0] ADDR_LO = 8'h82;
    localparam logic [7:0] ADDR_HI = 8'h83;
    localparam logic [7:0] LO_KEEP = 8'h7F;
    localparam logic [7:0] HI_KEEP = 8'h1F;

    typedef enum logic [1:0] {
        MODE_PRBS   = 2'd0,
        MODE_REPEAT = 2'd1,
        MODE_QRSS   = 2'd2
    } mode_e;

    typedef struct packed {
        mode_e             mode;
        logic [FLD_W-1:0]  len_m1;
        logic [FLD_W-1:0]  tap_m1;
    } cfg_t;

    function automatic logic [WORD_W-1:0] len_mask(input logic [FLD_W-1:0] lm);
        return {WORD_W{1'b1}} >> (WORD_W - 1 - int'(lm));
    endfunction
endpackage

// File: rtl/testpat_regs.sv
`timescale 1ns/1ps
module testpat_regs
    import testpat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       load,
    output cfg_t       cfg_new,
    output cfg_t       cfg_act
);
    typedef struct packed {
        logic [7:0] lo;
        logic [7:0] hi;
        cfg_t       act;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        if (r_q.lo[6]) begin
            cfg_new.mode   = MODE_QRSS;
            cfg_new.len_m1 = FLD_W'(QRSS_LEN - 1);
            cfg_new.tap_m1 = FLD_W'(QRSS_TAP - 1);
        end else begin
            cfg_new.mode   = r_q.lo[5] ? MODE_REPEAT : MODE_PRBS;
            cfg_new.len_m1 = r_q.lo[FLD_W-1:0];
            cfg_new.tap_m1 = r_q.hi[FLD_W-1:0];
        end
    end

    always_comb begin
        r_d = r_q;
        if (wr_en && wr_addr == ADDR_LO) r_d.lo = wr_data & LO_KEEP;
        if (wr_en && wr_addr == ADDR_HI) r_d.hi = wr_data & HI_KEEP;
        if (load)                        r_d.act = cfg_new;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.lo  <= '0;
            r_q.hi  <= '0;
            r_q.act <= '{mode: MODE_PRBS, len_m1: '0, tap_m1: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_act = r_q.act;

    // R2: a write to the low address lands masked in the shadow
    a_r2_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_LO) |=> r_q.lo == ($past(wr_data) & LO_KEEP));
    // R2: a write to the high address lands masked in the shadow
    a_r2_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_HI) |=> r_q.hi == ($past(wr_data) & HI_KEEP));
    // R2: active configuration changes only through a load
    a_r2_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(r_q.act));
endmodule

// File: rtl/testpat_shifter.sv
`timescale 1ns/1ps
module testpat_shifter
    import testpat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic [WORD_W-1:0] pattern_word,
    input  mode_e             new_mode,
    input  logic [FLD_W-1:0]  new_len_m1,
    input  cfg_t              cfg_act,
    output logic [WORD_W-1:0] state,
    output logic              raw_bit
);
    logic [WORD_W-1:0] state_d, state_q;
    logic [WORD_W-1:0] mask_new, mask_act, seed;
    logic              fb;

    always_comb begin
        mask_new = len_mask(new_len_m1);
        mask_act = len_mask(cfg_act.len_m1);
        seed     = pattern_word & mask_new;
        fb       = state_q[cfg_act.len_m1] ^ state_q[cfg_act.tap_m1];
        state_d  = state_q;
        if (load) begin
            if (new_mode != MODE_REPEAT && seed == '0) state_d = mask_new;
            else                                       state_d = seed;
        end else if (adv) begin
            if (cfg_act.mode == MODE_REPEAT) begin
                state_d = state_q >> 1;
                state_d[cfg_act.len_m1] = state_q[0];
            end else begin
                state_d = ((state_q << 1) | WORD_W'(fb)) & mask_act;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '1;
        else        state_q <= state_d;
    end

    assign state   = state_q;
    assign raw_bit = (cfg_act.mode == MODE_REPEAT) ? state_q[0] : state_q[cfg_act.len_m1];

    // R4: no advance and no load leaves the register untouched
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(state_q));
    // R6: a feedback-mode load never leaves an all-zero register
    a_r6_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
        (load && new_mode != MODE_REPEAT) |=> state_q != '0);
endmodule

// File: rtl/testpat_zsup.sv
`timescale 1ns/1ps
module testpat_zsup
    import testpat_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            adv,
    input  mode_e           mode,
    input  logic            raw_bit,
    input  logic [ZRUN-1:0] window,
    output logic            bit_out
);
    logic force_one;

    always_comb begin
        force_one = (mode == MODE_QRSS) && (window == '0);
        bit_out   = raw_bit | force_one;
    end

    // checker: length of the current zero run in quasi-random mode
    logic [$clog2(WORD_W)+1:0] zrun_d, zrun_q;
    always_comb begin
        zrun_d = zrun_q;
        if (load)                            zrun_d = '0;
        else if (adv && mode == MODE_QRSS)   zrun_d = bit_out ? '0 : zrun_q + 1'b1;
    end
    always_ff @(posedge clk) begin
        if (!rst_n) zrun_q <= '0;
        else        zrun_q <= zrun_d;
    end

    // R9: suppressed output never exceeds the zero-run bound
    a_r9_zero_run: assert property (@(posedge clk) disable iff (!rst_n)
        zrun_q <= ZRUN);
endmodule

// File: rtl/testpat_gen.sv
`timescale 1ns/1ps
module testpat_gen
    import testpat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [WORD_W-1:0] pattern_word,
    input  logic              load,
    input  logic              bit_en,
    output logic              bit_out
);
    cfg_t              cfg_new, cfg_act;
    logic [WORD_W-1:0] state;
    logic              raw_bit;
    logic              adv;

    assign adv = bit_en && !load;

    testpat_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (load),
        .cfg_new (cfg_new),
        .cfg_act (cfg_act)
    );

    testpat_shifter u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .adv          (adv),
        .pattern_word (pattern_word),
        .new_mode     (cfg_new.mode),
        .new_len_m1   (cfg_new.len_m1),
        .cfg_act      (cfg_act),
        .state        (state),
        .raw_bit      (raw_bit)
    );

    testpat_zsup u_zsup (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .adv     (adv),
        .mode    (cfg_act.mode),
        .raw_bit (raw_bit),
        .window  (state[QRSS_LEN-2 -: ZRUN]),
        .bit_out (bit_out)
    );
endmodule

// File: tb/testpat_gen_tb.sv
`timescale 1ns/1ps
module testpat_gen_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [7:0]  wr_addr = 0;
    logic [7:0]  wr_data = 0;
    logic [31:0] pattern_word = 0;
    logic        load = 0;
    logic        bit_en = 0;
    logic        bit_out;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // bench-side configuration and model
    logic [7:0]  b_lo = 0, b_hi = 0;
    logic [31:0] m_state = '1;
    int          m_mode = 0;   // 0 PRBS, 1 repeat, 2 quasi-random
    int          m_n = 1, m_y = 1;

    always #4 clk = ~clk;

    testpat_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pattern_word(pattern_word), .load(load),
        .bit_en(bit_en), .bit_out(bit_out)
    );

    function automatic logic [31:0] mmask(int n);
        return 32'hFFFF_FFFF >> (32 - n);
    endfunction

    function automatic logic [31:0] mnext(logic [31:0] s);
        if (m_mode == 1) return (s >> 1) | (32'(s[0]) << (m_n - 1));
        return ((s << 1) | 32'(s[m_n-1] ^ s[m_y-1])) & mmask(m_n);
    endfunction

    function automatic logic mraw(logic [31:0] s);
        return (m_mode == 1) ? s[0] : s[m_n-1];
    endfunction

    function automatic logic mout();
        logic [31:0] t;
        logic z;
        if (m_mode != 2) return mraw(m_state);
        t = m_state;
        z = 1'b1;
        for (int k = 0; k < 14; k++) begin
            t = mnext(t);
            if (mraw(t)) z = 1'b0;
        end
        return mraw(m_state) | z;
    endfunction

    task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        if (a == 8'h82) b_lo = d & 8'h7F;
        if (a == 8'h83) b_hi = d & 8'h1F;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic do_load(logic [31:0] pat);
        logic [31:0] sd;
        @(negedge clk);
        pattern_word = pat; load = 1;
        if (b_lo[6]) begin m_mode = 2; m_n = 20; m_y = 17; end
        else begin m_mode = b_lo[5] ? 1 : 0; m_n = b_lo[4:0] + 1; m_y = b_hi[4:0] + 1; end
        sd = pat & mmask(m_n);
        m_state = (m_mode != 1 && sd == 0) ? mmask(m_n) : sd;
        @(negedge clk);
        load = 0;
    endtask

    // check `count` bits against the model; first bit is sampled right away
    task automatic run_bits(int count, string tag);
        for (int i = 0; i < count; i++) begin
            if (i != 0) @(negedge clk);
            chk(32'(bit_out), 32'(mout()), tag);
            bit_en = 1;
            @(posedge clk);
            m_state = mnext(m_state);
        end
        @(negedge clk);
        bit_en = 0;
    endtask

    task automatic t_reset();
        chk(32'(bit_out), 32'd1, "R1 reset output");
    endtask

    task automatic t_prbs_short();
        logic [6:0] got;
        wr(8'h82, 8'h02);
        wr(8'h83, 8'h01);
        do_load(32'h0);
        chk(32'(bit_out), 32'd1, "R6 zero seed filled with ones");
        for (int i = 0; i < 7; i++) begin
            got[6-i] = bit_out;
            bit_en = 1; @(posedge clk); m_state = mnext(m_state);
            @(negedge clk); bit_en = 0;
        end
        chk(32'(got), 32'b1110010, "R5 3-stage sequence");
        run_bits(21, "R5 3-stage model");
    endtask

    task automatic t_hold();
        logic v;
        wr(8'h82, 8'h04);
        wr(8'h83, 8'h02);
        do_load(32'h13);
        chk(32'(bit_out), 32'(mout()), "R3 first bit after load");
        v = bit_out;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(32'(bit_out), 32'(v), "R4 hold without bit_en");
        end
        run_bits(40, "R4 resumes after hold");
    endtask

    task automatic t_deferred();
        wr(8'h82, 8'h27);          // repeat, 8 bits: not active before load
        wr(8'h83, 8'h00);
        run_bits(20, "R2 write deferred until load");
        wr(8'h84, 8'hFF);          // ignored address
        wr(8'h00, 8'h40);
        do_load(32'h0000_00C3);
        run_bits(24, "R2 other addresses ignored");
    endtask

    task automatic t_repeat();
        logic [7:0] got;
        wr(8'h82, 8'h27);
        wr(8'h83, 8'h11);
        do_load(32'hFFFF_FFA5);
        for (int i = 0; i < 8; i++) begin
            got[i] = bit_out;
            bit_en = 1; @(posedge clk); m_state = mnext(m_state);
            @(negedge clk); bit_en = 0;
        end
        chk(32'(got), 32'hA5, "R7 bit 0 first, 8-bit pattern");
        run_bits(24, "R7 8-bit repeat");
        wr(8'h83, 8'h03);
        do_load(32'hFFFF_FFA5);
        run_bits(16, "R7 tap ignored");
        wr(8'h82, 8'h3F);
        do_load(32'h8000_0001);
        run_bits(70, "R7 32-bit repeat");
        wr(8'h82, 8'h20);
        do_load(32'hFFFF_FFFF);
        run_bits(6, "R7 1-bit repeat");
        wr(8'h82, 8'h23);
        do_load(32'h0);
        chk(32'(bit_out), 32'd0, "R7 zero pattern kept");
        run_bits(8, "R7 zero pattern kept");
    endtask

    task automatic t_prbs15();
        logic first [200];
        int ones = 0;
        wr(8'h82, 8'h0E);
        wr(8'h83, 8'h0D);
        do_load(32'h1);
        for (int i = 0; i < 32767 + 200; i++) begin
            if (i != 0) @(negedge clk);
            chk(32'(bit_out), 32'(mout()), "R5 15-stage model");
            if (i < 32767) ones += int'(bit_out);
            if (i < 200) first[i] = bit_out;
            else if (i >= 32767) chk(32'(bit_out), 32'(first[i-32767]), "R10 period 32767");
            bit_en = 1;
            @(posedge clk);
            m_state = mnext(m_state);
        end
        @(negedge clk); bit_en = 0;
        chk(32'(ones), 32'd16384, "R10 ones per period");
    endtask

    task automatic t_qrss_force();
        logic [20:0] got;
        int run = 0, maxrun = 0;
        wr(8'h82, 8'h13);          // PRBS, 20 stages
        wr(8'h83, 8'h10);          // tap 17
        do_load(32'h0008_0000);
        for (int i = 0; i < 21; i++) begin
            if (bit_out) run = 0; else run++;
            if (run > maxrun) maxrun = run;
            bit_en = 1; @(posedge clk); m_state = mnext(m_state);
            @(negedge clk); bit_en = 0;
        end
        chk(32'(maxrun), 32'd19, "R9 no forcing in PRBS mode");
        wr(8'h82, 8'h6A);          // quasi-random with other fields set
        wr(8'h83, 8'h05);
        do_load(32'h0008_0000);
        for (int i = 0; i < 21; i++) begin
            got[i] = bit_out;
            bit_en = 1; @(posedge clk); m_state = mnext(m_state);
            @(negedge clk); bit_en = 0;
        end
        chk(32'(got), 32'h10_003F, "R9 six ones then fourteen zeros");
        run_bits(60, "R8 fields ignored in quasi-random mode");
    endtask

    task automatic t_qrss_long();
        int run = 0, maxrun = 0;
        wr(8'h82, 8'h40);
        do_load(32'h0);
        for (int i = 0; i < 40000; i++) begin
            if (i != 0) @(negedge clk);
            chk(32'(bit_out), 32'(mout()), "R9 quasi-random model");
            if (bit_out) run = 0; else run++;
            if (run > maxrun) maxrun = run;
            bit_en = 1;
            @(posedge clk);
            m_state = mnext(m_state);
        end
        @(negedge clk); bit_en = 0;
        vectors++;
        if (maxrun > 14) begin
            fails++;
            $display("FAIL R9 zero run: actual %0d expected at most 14", maxrun);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_prbs_short();
        t_hold();
        t_deferred();
        t_repeat();
        t_prbs15();
        t_qrss_force();
        t_qrss_long();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule